// File: doc/BRIEF.md
# Watchdog Timer with Safe-State Port Override

This block supervises a piece of software with a programmable countdown. Software loads a 32-bit interval, counted in 100 ns ticks, sets the run enable and then has to ping the block before the interval runs out. Each ping restarts the count from the programmed interval. When the count runs out, or when an enabled edge arrives on an external trigger line, the block enters an expired state. That state is sticky. In it the block forces selected I/O ports into a safe condition, emits a fixed-width pulse and can raise an interrupt.

The 100 ns time base is a one-cycle enable `tick_i`, derived outside the block from a 10 MHz reference. The per-port safe configuration is captured at the moment of expiry. For each port it selects one of three behaviours: float the port (output enables low), drive a fixed value (all output enables high), or leave the port alone. Only a clear strobe returns the ports to normal operation.

The control state machine has three states. `ST_IDLE` means not running. `ST_COUNT` means counting down. `ST_EXPIRED` means the safe state is applied. The transitions are:
- START: `ST_IDLE` to `ST_COUNT`, when the enable is high; this loads the interval.
- STOP: `ST_COUNT` to `ST_IDLE`, when the enable is low.
- REARM: `ST_COUNT` to `ST_COUNT`, on a ping; this reloads the interval.
- TIMEOUT: `ST_COUNT` to `ST_EXPIRED`, on a tick while the count is zero and no ping is present.
- TRIGGER: `ST_COUNT` to `ST_EXPIRED`, on an enabled trigger edge; this overrides a ping.
- RECOVER: `ST_EXPIRED` to `ST_IDLE`, on the clear strobe.

Top module: `watchdog_safeout`

## Requirements
- R1: After reset `expired_o`, `pulse_o` and `irq_o` are 0, and while not expired `port_dout_o`/`port_oe_o` equal `port_dout_i`/`port_oe_i`.
- R2: While `sw_enable_i` is 0 and the block is not expired, no tick and no trigger edge can cause expiry.
- R3: Enabling loads `timeout_i` = T into the count. Each later tick decrements a nonzero count. `expired_o` rises in the cycle after the (T+1)-th tick.
- R4: A ping while counting reloads T. A ping in the same cycle as the tick that would expire wins, and no expiry occurs.
- R5: With T = 0, the first tick after enabling causes expiry.
- R6: Expiry is sticky. Pings, ticks and a low `sw_enable_i` do not clear `expired_o`.
- R7: A one-cycle `clear_i` while expired drops `expired_o` on the next edge and restores passthrough. If the enable is still high, the count restarts from T.
- R8: A port whose float bit (`hiz_en_i[p]`) was 1 at expiry has all output enables 0 and data 0 while expired.
- R9: A port with its drive bit set and its float bit clear at expiry has all output enables 1 and outputs the safe value captured at expiry. A port with neither bit set passes through. Changing the configuration inputs after expiry has no effect.
- R10: `pulse_o` rises with `expired_o` and falls at the second tick after its start; with ticks every 10 cycles after a timeout it is high for 20 cycles.
- R11: While counting, a rising edge of `ext_trig_i` (when `trig_rise_en_i`) or a falling edge (when `trig_fall_en_i`) forces expiry, after a two-flop synchronizer. An edge of a disabled polarity does nothing.
- R12: `irq_o` is high exactly while expired and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 ns time-base enable |
| sw_enable_i | input | 1 | Watchdog run enable |
| timeout_i | input | 32 | Interval in ticks |
| ping_i | input | 1 | Restart strobe |
| clear_i | input | 1 | Clear-expiry strobe |
| hiz_en_i | input | NPORTS | Per-port float-on-expiry select |
| drive_en_i | input | NPORTS | Per-port drive-on-expiry select |
| safe_val_i | input | NPORTS*PORT_W | Per-port safe data values |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| trig_rise_en_i | input | 1 | Rising trigger edge forces expiry |
| trig_fall_en_i | input | 1 | Falling trigger edge forces expiry |
| irq_en_i | input | 1 | Interrupt enable |
| port_dout_i | input | NPORTS*PORT_W | Normal port data |
| port_oe_i | input | NPORTS*PORT_W | Normal port output enables |
| port_dout_o | output | NPORTS*PORT_W | Port data after override |
| port_oe_o | output | NPORTS*PORT_W | Port output enables after override |
| expired_o | output | 1 | Sticky expiry status |
| pulse_o | output | 1 | Expiry pulse, two ticks long |
| irq_o | output | 1 | Expiry interrupt |

## Verification
Two pairs of events can land in the same clock cycle: a ping with the tick that would end the count, and a ping with a synchronized trigger edge. The bench runs the count down to zero and then raises the ping and the tick in one cycle. Expiry must not follow, and exactly T+1 further ticks must be needed after that. For the second pair, the trigger edge is placed while pings keep arriving, and expiry is still required. A sweep over every interval from 0 to 5 and over all 256 float/drive combinations of four ports checks the expiry timing and the override values against figures computed in the bench.

// File: rtl/wd_pkg.sv
package wd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wd_trig_edge.sv
module wd_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    output logic edge_evt_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               synced;
    logic               prev;

    // synchronizer stages plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], trig_i};
        end
    end

    assign synced = chain_q[SYNC_STAGES-1];
    assign prev   = chain_q[SYNC_STAGES];

    always_comb begin
        edge_evt_o = (rise_en_i & synced & ~prev) |
                     (fall_en_i & ~synced & prev);
    end
endmodule

// File: rtl/wd_down_counter.sv
module wd_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (run_i && tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wd_ctrl_fsm.sv
module wd_ctrl_fsm
    import wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic ping_i,
    input  logic clear_i,
    input  logic tick_i,
    input  logic cnt_zero_i,
    input  logic trig_evt_i,
    output logic load_o,
    output logic run_o,
    output logic expire_evt_o,
    output logic expired_o
);
    wd_state_t state_q;
    wd_state_t state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_i) state_d = ST_COUNT;            // START
            end
            ST_COUNT: begin
                if (!enable_i)                 state_d = ST_IDLE;     // STOP
                else if (trig_evt_i)           state_d = ST_EXPIRED;  // TRIGGER
                else if (ping_i)               state_d = ST_COUNT;    // REARM
                else if (tick_i && cnt_zero_i) state_d = ST_EXPIRED;  // TIMEOUT
            end
            ST_EXPIRED: begin
                if (clear_i) state_d = ST_IDLE;              // RECOVER
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        load_o       = 1'b0;
        run_o        = 1'b0;
        expire_evt_o = 1'b0;
        expired_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = enable_i;
            end
            ST_COUNT: begin
                run_o        = 1'b1;
                load_o       = enable_i && ping_i && !trig_evt_i;
                expire_evt_o = (state_d == ST_EXPIRED);
            end
            ST_EXPIRED: begin
                expired_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wd_pulse_gen.sv
module wd_pulse_gen #(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wd_port_override.sv
module wd_port_override #(
    parameter int NPORTS = 4,
    parameter int PORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture_i,
    input  logic                     active_i,
    input  logic [NPORTS-1:0]        hiz_en_i,
    input  logic [NPORTS-1:0]        drive_en_i,
    input  logic [NPORTS*PORT_W-1:0] safe_val_i,
    input  logic [NPORTS*PORT_W-1:0] dout_i,
    input  logic [NPORTS*PORT_W-1:0] oe_i,
    output logic [NPORTS*PORT_W-1:0] dout_o,
    output logic [NPORTS*PORT_W-1:0] oe_o
);
    logic [NPORTS-1:0]        hiz_q;
    logic [NPORTS-1:0]        drv_q;
    logic [NPORTS*PORT_W-1:0] safe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q  <= '0;
            drv_q  <= '0;
            safe_q <= '0;
        end else if (capture_i) begin
            hiz_q  <= hiz_en_i;
            drv_q  <= drive_en_i;
            safe_q <= safe_val_i;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_comb begin
            if (active_i && hiz_q[p]) begin
                dout_o[p*PORT_W +: PORT_W] = '0;
                oe_o[p*PORT_W +: PORT_W]   = '0;
            end else if (active_i && drv_q[p]) begin
                dout_o[p*PORT_W +: PORT_W] = safe_q[p*PORT_W +: PORT_W];
                oe_o[p*PORT_W +: PORT_W]   = '1;
            end else begin
                dout_o[p*PORT_W +: PORT_W] = dout_i[p*PORT_W +: PORT_W];
                oe_o[p*PORT_W +: PORT_W]   = oe_i[p*PORT_W +: PORT_W];
            end
        end
    end
endmodule

// File: rtl/watchdog_safeout.sv
module watchdog_safeout #(
    parameter int NPORTS      = 4,
    parameter int PORT_W      = 8,
    parameter int TIMEOUT_W   = 32,
    parameter int PULSE_TICKS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     sw_enable_i,
    input  logic [TIMEOUT_W-1:0]     timeout_i,
    input  logic                     ping_i,
    input  logic                     clear_i,
    input  logic [NPORTS-1:0]        hiz_en_i,
    input  logic [NPORTS-1:0]        drive_en_i,
    input  logic [NPORTS*PORT_W-1:0] safe_val_i,
    input  logic                     ext_trig_i,
    input  logic                     trig_rise_en_i,
    input  logic                     trig_fall_en_i,
    input  logic                     irq_en_i,
    input  logic [NPORTS*PORT_W-1:0] port_dout_i,
    input  logic [NPORTS*PORT_W-1:0] port_oe_i,
    output logic [NPORTS*PORT_W-1:0] port_dout_o,
    output logic [NPORTS*PORT_W-1:0] port_oe_o,
    output logic                     expired_o,
    output logic                     pulse_o,
    output logic                     irq_o
);
    logic trig_evt;
    logic cnt_zero;
    logic load;
    logic run;
    logic expire_evt;
    logic expired;

    wd_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (ext_trig_i),
        .rise_en_i  (trig_rise_en_i),
        .fall_en_i  (trig_fall_en_i),
        .edge_evt_o (trig_evt)
    );

    wd_down_counter #(.CNT_W(TIMEOUT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .run_i    (run),
        .tick_i   (tick_i),
        .reload_i (timeout_i),
        .zero_o   (cnt_zero)
    );

    wd_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (sw_enable_i),
        .ping_i       (ping_i),
        .clear_i      (clear_i),
        .tick_i       (tick_i),
        .cnt_zero_i   (cnt_zero),
        .trig_evt_i   (trig_evt),
        .load_o       (load),
        .run_o        (run),
        .expire_evt_o (expire_evt),
        .expired_o    (expired)
    );

    wd_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (expire_evt),
        .tick_i  (tick_i),
        .pulse_o (pulse_o)
    );

    wd_port_override #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_ovr (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (expire_evt),
        .active_i   (expired),
        .hiz_en_i   (hiz_en_i),
        .drive_en_i (drive_en_i),
        .safe_val_i (safe_val_i),
        .dout_i     (port_dout_i),
        .oe_i       (port_oe_i),
        .dout_o     (port_dout_o),
        .oe_o       (port_oe_o)
    );

    assign expired_o = expired;
    assign irq_o     = expired & irq_en_i;
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
    parameter int NPORTS = 4,
    parameter int PORT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sw_enable_i,
    input logic                     clear_i,
    input logic [NPORTS*PORT_W-1:0] port_dout_i,
    input logic [NPORTS*PORT_W-1:0] port_oe_i,
    input logic [NPORTS*PORT_W-1:0] port_dout_o,
    input logic [NPORTS*PORT_W-1:0] port_oe_o,
    input logic                     expired_o,
    input logic                     pulse_o,
    input logic                     irq_o
);
    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !expired_o |-> (port_dout_o == port_dout_i) && (port_oe_o == port_oe_i));

    assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_enable_i && !expired_o) |=> !expired_o);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i) |=> expired_o);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && clear_i) |=> !expired_o);

    assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $rose(expired_o));

    assert_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> expired_o);
endmodule

bind watchdog_safeout wd_checker #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_enable_i (sw_enable_i),
    .clear_i     (clear_i),
    .port_dout_i (port_dout_i),
    .port_oe_i   (port_oe_i),
    .port_dout_o (port_dout_o),
    .port_oe_o   (port_oe_o),
    .expired_o   (expired_o),
    .pulse_o     (pulse_o),
    .irq_o       (irq_o)
);

// File: tb/watchdog_safeout_tb.sv
module watchdog_safeout_tb;
    localparam int NP = 4;
    localparam int PW = 8;
    localparam int DW = NP * PW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_i;
    logic          sw_enable_i;
    logic [31:0]   timeout_i;
    logic          ping_i;
    logic          clear_i;
    logic [NP-1:0] hiz_en_i;
    logic [NP-1:0] drive_en_i;
    logic [DW-1:0] safe_val_i;
    logic          ext_trig_i;
    logic          trig_rise_en_i;
    logic          trig_fall_en_i;
    logic          irq_en_i;
    logic [DW-1:0] port_dout_i;
    logic [DW-1:0] port_oe_i;
    logic [DW-1:0] port_dout_o;
    logic [DW-1:0] port_oe_o;
    logic          expired_o;
    logic          pulse_o;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    watchdog_safeout #(.NPORTS(NP), .PORT_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sw_enable_i(sw_enable_i),
        .timeout_i(timeout_i), .ping_i(ping_i), .clear_i(clear_i),
        .hiz_en_i(hiz_en_i), .drive_en_i(drive_en_i), .safe_val_i(safe_val_i),
        .ext_trig_i(ext_trig_i), .trig_rise_en_i(trig_rise_en_i),
        .trig_fall_en_i(trig_fall_en_i), .irq_en_i(irq_en_i),
        .port_dout_i(port_dout_i), .port_oe_i(port_oe_i),
        .port_dout_o(port_dout_o), .port_oe_o(port_oe_o),
        .expired_o(expired_o), .pulse_o(pulse_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
        step();
    endtask

    task automatic disarm();
        sw_enable_i = 1'b0;
        clear_i     = 1'b1;
        step();
        clear_i = 1'b0;
        step();
    endtask

    task automatic arm(input logic [31:0] t);
        timeout_i   = t;
        sw_enable_i = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] exp_d;
        logic [DW-1:0] exp_o;
        int            hi_cnt;
        rst_n = 1'b0; tick_i = 0; sw_enable_i = 0; timeout_i = 0; ping_i = 0; clear_i = 0;
        hiz_en_i = 0; drive_en_i = 0; safe_val_i = 0; ext_trig_i = 0;
        trig_rise_en_i = 0; trig_fall_en_i = 0; irq_en_i = 0;
        port_dout_i = 32'h1234_5678; port_oe_i = 32'h0F0F_00FF;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(expired_o == 0 && pulse_o == 0 && irq_o == 0, "R1 reset flags", {expired_o, pulse_o, irq_o}, 0);
        chk(port_dout_o == port_dout_i && port_oe_o == port_oe_i, "R1 passthrough", port_oe_o, port_oe_i);

        // R2 disabled: ticks and trigger edges do nothing
        trig_rise_en_i = 1;
        for (int i = 0; i < 5; i++) do_tick();
        ext_trig_i = 1; repeat (5) step(); ext_trig_i = 0; repeat (5) step();
        chk(expired_o == 0, "R2 no expiry while disabled", expired_o, 0);
        trig_rise_en_i = 0;

        // R3 / R5 sweep of intervals
        for (int t = 0; t <= 5; t++) begin
            disarm();
            arm(t);
            for (int k = 0; k < t; k++) do_tick();
            chk(expired_o == 0, t == 0 ? "R5 not before tick" : "R3 not before T+1 ticks", expired_o, 0);
            do_tick();
            chk(expired_o == 1, t == 0 ? "R5 zero interval expiry" : "R3 expiry at T+1 tick", expired_o, 1);
        end

        // R4 ping coinciding with the expiring tick
        disarm();
        arm(3);
        for (int k = 0; k < 3; k++) do_tick();
        ping_i = 1; tick_i = 1; step(); ping_i = 0; tick_i = 0; step();
        chk(expired_o == 0, "R4 ping wins over expiring tick", expired_o, 0);
        for (int k = 0; k < 3; k++) do_tick();
        chk(expired_o == 0, "R4 reloaded count not yet out", expired_o, 0);
        do_tick();
        chk(expired_o == 1, "R4 expiry after reload", expired_o, 1);

        // R12 interrupt gating
        irq_en_i = 0; step();
        chk(irq_o == 0, "R12 irq masked", irq_o, 0);
        irq_en_i = 1; step();
        chk(irq_o == 1, "R12 irq raised", irq_o, 1);

        // R6 sticky
        ping_i = 1; step(); ping_i = 0;
        do_tick();
        sw_enable_i = 0; repeat (3) step();
        chk(expired_o == 1 && irq_o == 1, "R6 sticky expiry", expired_o, 1);

        // R7 clear restarts with reload
        timeout_i = 1; sw_enable_i = 1;
        clear_i = 1; step(); clear_i = 0;
        chk(expired_o == 0 && irq_o == 0, "R7 cleared", expired_o, 0);
        chk(port_dout_o == port_dout_i && port_oe_o == port_oe_i, "R7 passthrough restored", port_dout_o, port_dout_i);
        step();
        do_tick();
        chk(expired_o == 0, "R7 restart counting", expired_o, 0);
        do_tick();
        chk(expired_o == 1, "R7 expiry after restart", expired_o, 1);
        irq_en_i = 0;

        // R10 pulse width
        disarm();
        arm(0);
        tick_i = 1; step(); tick_i = 0;
        hi_cnt = pulse_o ? 1 : 0;
        chk(pulse_o == 1 && expired_o == 1, "R10 pulse starts with expiry", pulse_o, 1);
        for (int i = 1; i <= 40; i++) begin
            tick_i = (i % 10 == 0);
            step();
            if (pulse_o) hi_cnt++;
        end
        tick_i = 0;
        chk(hi_cnt == 20, "R10 pulse lasts two ticks", hi_cnt, 20);

        // R11 trigger edges
        disarm();
        arm(100);
        trig_fall_en_i = 1;
        ext_trig_i = 1; repeat (5) step();
        chk(expired_o == 0, "R11 rising edge ignored when only falling enabled", expired_o, 0);
        ping_i = 1;
        ext_trig_i = 0; repeat (5) step();
        ping_i = 0;
        chk(expired_o == 1, "R11 falling edge forces expiry over pings", expired_o, 1);
        trig_fall_en_i = 0;
        disarm();
        arm(100);
        trig_rise_en_i = 1;
        ext_trig_i = 1; repeat (5) step();
        chk(expired_o == 1, "R11 rising edge forces expiry", expired_o, 1);
        trig_rise_en_i = 0; ext_trig_i = 0; repeat (4) step();

        // R8 / R9 sweep of all float/drive combinations
        for (int h = 0; h < 16; h++) begin
            for (int d = 0; d < 16; d++) begin
                disarm();
                hiz_en_i   = h[NP-1:0];
                drive_en_i = d[NP-1:0];
                safe_val_i = {8'(h * 16 + d), 8'hC3, 8'(d ^ 8'h5A), 8'(h + 8'h20)};
                for (int p = 0; p < NP; p++) begin
                    if (h[p]) begin
                        exp_d[p*PW +: PW] = '0;
                        exp_o[p*PW +: PW] = '0;
                    end else if (d[p]) begin
                        exp_d[p*PW +: PW] = safe_val_i[p*PW +: PW];
                        exp_o[p*PW +: PW] = '1;
                    end else begin
                        exp_d[p*PW +: PW] = port_dout_i[p*PW +: PW];
                        exp_o[p*PW +: PW] = port_oe_i[p*PW +: PW];
                    end
                end
                arm(0);
                do_tick();
                chk(port_oe_o == exp_o, "R8 R9 override enables", port_oe_o, exp_o);
                chk(port_dout_o == exp_d, "R8 R9 override data", port_dout_o, exp_d);
                hiz_en_i = ~hiz_en_i; drive_en_i = ~drive_en_i; safe_val_i = ~safe_val_i;
                step();
                chk(port_oe_o == exp_o && port_dout_o == exp_d, "R9 captured at expiry", port_dout_o, exp_d);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule